// File: doc/BRIEF.md
# Instruction Fetch and Addressing Sequencer

This block is the control sequencer of a single-accumulator machine with 16-bit words and 12-bit addresses. A 4-bit step counter is decoded into sixteen one-hot timing states. Each instruction uses five of them.

1. The program counter is copied into the address register.
2. The addressed word is loaded into the instruction register, and the program counter advances.
3. The opcode is decoded, and the address field is copied into the address register.
4. If the indirect flag is set, the word at that address replaces the address.
5. The operand is read into the data register, and a completion strobe pulses.

The counter then wraps back to the first state. The block exposes the bus-source select and the load, increment and clear controls it generates, so the surrounding datapath or a monitor can follow every transfer.

The block holds its own program counter, address, instruction and data registers, and a small word memory. The memory is filled through a write port. Arithmetic execution is outside this block. Opcode 7 is a halt: it stops the sequencer after the decode step, and a pulse on the start input resumes fetching at the next instruction.

Top module: `fetch_seq`

## Requirements
- R1: While rst_n is low, pc, ar, ir and dr are zero, running is 1 and t_state is 16'h0001.
- R2: While running, t_state is one-hot with bit k set when the step counter holds k. States run T0, T1, T2, T3, T4 and return to T0 after T4. t_state is all zeros while halted.
- R3: In T0 bus_sel is 2 (program counter) and ld_ar is 1, so ar takes pc at the clock edge that ends T0.
- R4: In T1 bus_sel is 7 (memory), ld_ir and inc_pc are 1, so ir takes the memory word at ar and pc increases by one at the edge that ends T1. ir changes at no other time.
- R5: ind equals ir bit 15, and op_dec is the one-hot decode of ir bits 14..12 (bit n set for opcode n).
- R6: In T2 bus_sel is 5 (instruction register) and ar takes ir bits 11..0.
- R7: In T3 with ind set, bus_sel is 7 and ar takes the memory word at ar. With ind clear, ar is unchanged through T3.
- R8: In T4 bus_sel is 7, dr takes the memory word at ar, and done is 1. done is 0 in every other state.
- R9: Opcode 7 in T2 clears running at the edge that ends T2. No T3 or T4 follows, done stays 0, and pc, ar, ir and dr hold while halted.
- R10: A start pulse while halted sets running at the next edge, and fetching restarts in T0 from the current pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Resume pulse after a halt |
| mem_we | input | 1 | Memory write enable |
| mem_waddr | input | 6 | Memory write address |
| mem_wdata | input | 16 | Memory write data |
| t_state | output | 16 | One-hot timing states |
| bus_sel | output | 3 | Bus source: 1 AR, 2 PC, 5 IR, 7 memory, 0 none |
| ld_ar | output | 1 | Address register load |
| ld_ir | output | 1 | Instruction register load |
| ld_dr | output | 1 | Data register load |
| inc_pc | output | 1 | Program counter increment |
| clr_sc | output | 1 | Step counter clear |
| op_dec | output | 8 | One-hot opcode decode |
| ind | output | 1 | Indirect flag |
| done | output | 1 | Operand fetched strobe |
| running | output | 1 | Sequencer active |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| dr | output | 16 | Data register |

## Verification
The assertions assume that start is pulsed only while the sequencer is halted or is harmless, and that the memory is not written while an instruction is in flight. A write during a run would let a word change between the read that fetches it and a later check. The bench loads every program word while reset is held and pulses start only after a halt has been observed. Addresses in the test program stay within the memory depth, because the memory is indexed by the low address bits.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_AR   = 3'd1,
    BUS_PC   = 3'd2,
    BUS_DR   = 3'd3,
    BUS_AC   = 3'd4,
    BUS_IR   = 3'd5,
    BUS_TR   = 3'd6,
    BUS_MEM  = 3'd7
  } bus_src_e;

  typedef struct packed {
    bus_src_e sel;
    logic     ld_ar;
    logic     ld_ir;
    logic     ld_dr;
    logic     inc_pc;
    logic     clr_sc;
    logic     halt;
    logic     done;
  } ctl_t;
endpackage

// File: rtl/fs_timing.sv
module fs_timing #(
  parameter int SC_W = 4,
  localparam int T_N = 1 << SC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           halt,
  input  logic           start,
  output logic [T_N-1:0] t_onehot,
  output logic           running
);
  logic [SC_W-1:0] sc_q, sc_nxt;
  logic            run_q, run_nxt;

  always_comb begin
    run_nxt = run_q;
    if (halt)               run_nxt = 1'b0;
    else if (start && !run_q) run_nxt = 1'b1;
    if (!run_q || clr || halt) sc_nxt = '0;
    else                       sc_nxt = sc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q  <= '0;
      run_q <= 1'b1;
    end else begin
      sc_q  <= sc_nxt;
      run_q <= run_nxt;
    end
  end

  for (genvar i = 0; i < T_N; i++) begin : g_tdec
    assign t_onehot[i] = run_q && (sc_q == SC_W'(i));
  end

  assign running = run_q;
endmodule

// File: rtl/fs_control.sv
module fs_control
  import fs_pkg::*;
#(
  parameter int OP_W = 3,
  parameter int T_N  = 16,
  localparam int N_OP = 1 << OP_W
) (
  input  logic [T_N-1:0]  t,
  input  logic [OP_W:0]   hdr,
  output ctl_t            ctl,
  output logic [N_OP-1:0] op_dec,
  output logic            ind
);
  localparam int HALT_OP = N_OP - 1;
  logic [OP_W-1:0] opcode;

  assign ind    = hdr[OP_W];
  assign opcode = hdr[OP_W-1:0];

  for (genvar n = 0; n < N_OP; n++) begin : g_opdec
    assign op_dec[n] = (opcode == OP_W'(n));
  end

  always_comb begin
    ctl = '0;
    if (t[0]) begin
      ctl.sel   = BUS_PC;
      ctl.ld_ar = 1'b1;
    end
    if (t[1]) begin
      ctl.sel    = BUS_MEM;
      ctl.ld_ir  = 1'b1;
      ctl.inc_pc = 1'b1;
    end
    if (t[2]) begin
      ctl.sel   = BUS_IR;
      ctl.ld_ar = 1'b1;
      if (op_dec[HALT_OP]) begin
        ctl.halt   = 1'b1;
        ctl.clr_sc = 1'b1;
      end
    end
    if (t[3] && ind) begin
      ctl.sel   = BUS_MEM;
      ctl.ld_ar = 1'b1;
    end
    if (t[4]) begin
      ctl.sel    = BUS_MEM;
      ctl.ld_dr  = 1'b1;
      ctl.done   = 1'b1;
      ctl.clr_sc = 1'b1;
    end
  end
endmodule

// File: rtl/fs_datapath.sv
module fs_datapath
  import fs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 6,
  localparam int MEM_D = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_src_e          sel,
  input  logic              ld_ar,
  input  logic              ld_ir,
  input  logic              ld_dr,
  input  logic              inc_pc,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_waddr,
  input  logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] dr
);
  logic [WORD_W-1:0] mem [MEM_D];
  logic [WORD_W-1:0] mem_rd, bus;
  logic [ADDR_W-1:0] pc_nxt, ar_nxt;
  logic [WORD_W-1:0] ir_nxt, dr_nxt;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  assign mem_rd = mem[ar[MEM_AW-1:0]];

  always_comb begin
    case (sel)
      BUS_AR:  bus = WORD_W'(ar);
      BUS_PC:  bus = WORD_W'(pc);
      BUS_DR:  bus = dr;
      BUS_IR:  bus = ir;
      BUS_MEM: bus = mem_rd;
      default: bus = '0;
    endcase
  end

  always_comb begin
    pc_nxt = inc_pc ? pc + 1'b1 : pc;
    ar_nxt = ld_ar ? bus[ADDR_W-1:0] : ar;
    ir_nxt = ld_ir ? bus : ir;
    dr_nxt = ld_dr ? bus : dr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ar <= '0;
      ir <= '0;
      dr <= '0;
    end else begin
      pc <= pc_nxt;
      ar <= ar_nxt;
      ir <= ir_nxt;
      dr <= dr_nxt;
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4,
  parameter int OP_W   = 3,
  parameter int MEM_AW = 6,
  localparam int T_N  = 1 << SC_W,
  localparam int N_OP = 1 << OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_waddr,
  input  logic [WORD_W-1:0] mem_wdata,
  output logic [T_N-1:0]    t_state,
  output logic [2:0]        bus_sel,
  output logic              ld_ar,
  output logic              ld_ir,
  output logic              ld_dr,
  output logic              inc_pc,
  output logic              clr_sc,
  output logic [N_OP-1:0]   op_dec,
  output logic              ind,
  output logic              done,
  output logic              running,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] dr
);
  ctl_t ctl;

  fs_timing #(.SC_W(SC_W)) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctl.clr_sc),
    .halt     (ctl.halt),
    .start    (start),
    .t_onehot (t_state),
    .running  (running)
  );

  fs_control #(.OP_W(OP_W), .T_N(T_N)) u_control (
    .t      (t_state),
    .hdr    (ir[WORD_W-1 -: OP_W+1]),
    .ctl    (ctl),
    .op_dec (op_dec),
    .ind    (ind)
  );

  fs_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (ctl.sel),
    .ld_ar     (ctl.ld_ar),
    .ld_ir     (ctl.ld_ir),
    .ld_dr     (ctl.ld_dr),
    .inc_pc    (ctl.inc_pc),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .pc        (pc),
    .ar        (ar),
    .ir        (ir),
    .dr        (dr)
  );

  assign bus_sel = ctl.sel;
  assign ld_ar   = ctl.ld_ar;
  assign ld_ir   = ctl.ld_ir;
  assign ld_dr   = ctl.ld_dr;
  assign inc_pc  = ctl.inc_pc;
  assign clr_sc  = ctl.clr_sc;
  assign done    = ctl.done;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int T_N    = 16,
  parameter int N_OP   = 8,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [T_N-1:0]    t_state,
  input logic [2:0]        bus_sel,
  input logic              ld_ir,
  input logic              inc_pc,
  input logic [N_OP-1:0]   op_dec,
  input logic              ind,
  input logic              done,
  input logic              running,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [WORD_W-1:0] ir,
  input logic [WORD_W-1:0] dr
);
  AST_T_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(t_state)); // R2
  AST_T4_WRAP: assert property (@(posedge clk) disable iff (!rst_n) t_state[4] |=> t_state[0]); // R2
  AST_T0_BUS: assert property (@(posedge clk) disable iff (!rst_n) t_state[0] |-> bus_sel == 3'd2); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) inc_pc |=> pc == $past(pc) + 1'b1); // R4
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_ir |=> $stable(ir)); // R4
  AST_OPDEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(op_dec)); // R5
  AST_DIRECT_AR: assert property (@(posedge clk) disable iff (!rst_n) (t_state[3] && !ind) |=> $stable(ar)); // R7
  AST_DONE_T4: assert property (@(posedge clk) disable iff (!rst_n) done |-> t_state[4]); // R8
  AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (t_state[2] && op_dec[N_OP-1]) |=> !running); // R9
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !running |-> (t_state == '0 && !done)); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (!running && $past(!running)) |-> ($stable(pc) && $stable(dr))); // R9
endmodule

bind fetch_seq fs_checker #(.T_N(T_N), .N_OP(N_OP), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .t_state (t_state),
  .bus_sel (bus_sel),
  .ld_ir   (ld_ir),
  .inc_pc  (inc_pc),
  .op_dec  (op_dec),
  .ind     (ind),
  .done    (done),
  .running (running),
  .pc      (pc),
  .ar      (ar),
  .ir      (ir),
  .dr      (dr)
);

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n, start, mem_we;
  logic [5:0]  mem_waddr;
  logic [15:0] mem_wdata;
  logic [15:0] t_state;
  logic [2:0]  bus_sel;
  logic        ld_ar, ld_ir, ld_dr, inc_pc, clr_sc;
  logic [7:0]  op_dec;
  logic        ind, done, running;
  logic [11:0] pc, ar;
  logic [15:0] ir, dr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .t_state(t_state),
    .bus_sel(bus_sel), .ld_ar(ld_ar), .ld_ir(ld_ir), .ld_dr(ld_dr),
    .inc_pc(inc_pc), .clr_sc(clr_sc), .op_dec(op_dec), .ind(ind),
    .done(done), .running(running), .pc(pc), .ar(ar), .ir(ir), .dr(dr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
    step();
    mem_we = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 pc", 32'(pc), 0);
    chk("R1 ar", 32'(ar), 0);
    chk("R1 ir", 32'(ir), 0);
    chk("R1 dr", 32'(dr), 0);
    chk("R1 running", 32'(running), 1);
    chk("R1 t_state", 32'(t_state), 32'h1);
    chk("R5 op_dec at reset", 32'(op_dec), 32'h01);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R3 T0 bus", 32'(bus_sel), 2);
    chk("R3 T0 ld_ar", 32'(ld_ar), 1);
  endtask

  // direct instruction at 0: opcode 1, address 0x10 -> 0xBEEF
  task automatic test_direct();
    step();
    chk("R2 T1", 32'(t_state), 32'h2);
    chk("R3 ar gets pc", 32'(ar), 0);
    chk("R4 T1 bus", 32'(bus_sel), 7);
    chk("R4 T1 inc_pc", 32'(inc_pc), 1);
    step();
    chk("R2 T2", 32'(t_state), 32'h4);
    chk("R4 ir", 32'(ir), 32'h1010);
    chk("R4 pc", 32'(pc), 1);
    chk("R5 op_dec", 32'(op_dec), 32'h02);
    chk("R5 ind", 32'(ind), 0);
    chk("R6 T2 bus", 32'(bus_sel), 5);
    step();
    chk("R6 ar addr field", 32'(ar), 32'h010);
    chk("R8 done off in T3", 32'(done), 0);
    step();
    chk("R7 direct ar held", 32'(ar), 32'h010);
    chk("R8 done", 32'(done), 1);
    chk("R8 T4 bus", 32'(bus_sel), 7);
    step();
    chk("R2 wrap T0", 32'(t_state), 32'h1);
    chk("R8 dr", 32'(dr), 32'hBEEF);
    chk("R8 done low", 32'(done), 0);
  endtask

  // indirect instruction at 1: opcode 0, address 0x11 -> 0x12 -> 0xCAFE
  task automatic test_indirect();
    step(); step();
    chk("R4 ir indirect", 32'(ir), 32'h8011);
    chk("R5 ind set", 32'(ind), 1);
    chk("R5 op_dec op0", 32'(op_dec), 32'h01);
    chk("R4 pc two", 32'(pc), 2);
    step();
    chk("R7 T3 bus", 32'(bus_sel), 7);
    chk("R7 T3 ld_ar", 32'(ld_ar), 1);
    step();
    chk("R7 pointer", 32'(ar), 32'h012);
    chk("R8 done ind", 32'(done), 1);
    step();
    chk("R8 dr indirect", 32'(dr), 32'hCAFE);
  endtask

  // halt at 2, then opcode 2 at 3: address 0x13 -> 0x1234
  task automatic test_halt_resume();
    step(); step();
    chk("R5 op_dec halt", 32'(op_dec), 32'h80);
    step();
    chk("R9 running cleared", 32'(running), 0);
    chk("R2 t_state idle", 32'(t_state), 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R9 done idle", 32'(done), 0);
    end
    chk("R9 pc held", 32'(pc), 3);
    chk("R9 ar held", 32'(ar), 0);
    chk("R9 dr held", 32'(dr), 32'hCAFE);
    chk("R9 ir held", 32'(ir), 32'h7000);
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R10 running", 32'(running), 1);
    chk("R10 T0", 32'(t_state), 32'h1);
    step();
    chk("R10 ar from pc", 32'(ar), 3);
    step();
    chk("R10 ir next", 32'(ir), 32'h2013);
    chk("R5 op_dec op2", 32'(op_dec), 32'h04);
    step(); step(); step();
    chk("R10 dr", 32'(dr), 32'h1234);
    chk("R2 back T0", 32'(t_state), 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    @(negedge clk);
    wr(6'h00, 16'h1010);
    wr(6'h01, 16'h8011);
    wr(6'h02, 16'h7000);
    wr(6'h03, 16'h2013);
    wr(6'h04, 16'h7000);
    wr(6'h10, 16'hBEEF);
    wr(6'h11, 16'h0012);
    wr(6'h12, 16'hCAFE);
    wr(6'h13, 16'h1234);
    test_reset();
    test_direct();
    test_indirect();
    test_halt_resume();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule